// File: doc/BRIEF.md
# Dual-Side Card Attribute Memory

This block is a small shared store that holds the configuration-facing data of a removable card. Two buses reach it. The host bus sees a sparse byte space in which only even offsets carry data. The local processor bus sees the same bytes packed densely and moves 16-bit words with per-byte enables. The storage is split into fixed typed regions, and the region decides who may write:

- two card-information areas that together hold 240 bytes, which the local software fills;
- eight base-address bytes;
- eight configuration bytes;
- a four-byte mailbox window.

Both buses share one storage port. When both request in the same cycle, the host is served first. The local bus sees `loc_ready` low for that cycle and keeps its request up until it is taken. Read data from either side appears in the cycle after the access is accepted.

Each host byte lives at local address 0x100 plus half the host offset. The dense local map runs as follows:

- 0x100–0x177: card information;
- 0x178–0x17F: base-address bytes;
- 0x180–0x187: configuration bytes;
- 0x188–0x1FF: card information;
- 0x200–0x203: mailbox.

Top module: `attr_dual_mem`

## Requirements
- R1: After a synchronous active-low reset, `host_rdata` and `loc_rdata` are zero and every stored byte reads back as zero.
- R2: An even host offset H in 0x000–0x1FE reads the byte held at local address 0x100 + H/2. This covers both card-information areas, the base-address bytes at host 0x0F0–0x0FE and the configuration bytes at host 0x100–0x10E.
- R3: A host access with offset bit 0 set reads 0x00, and a host write to such an offset changes no stored byte.
- R4: A host access whose translated local address falls in no region reads 0x00, and a host write there changes no stored byte. This covers host offsets 0x208 and above.
- R5: A host write to an even offset in the base-address, configuration or mailbox region stores `host_wdata` in the mapped byte, and the local side can read it.
- R6: A host write to either card-information area is ignored. The host can only read those bytes.
- R7: A local access addresses the 16-bit word at `{loc_addr[9:1],0}`, and `loc_addr[0]` is ignored. With `loc_be`=2'b11, `loc_wdata[7:0]` goes to the even byte and `loc_wdata[15:8]` to the odd byte at the next address. A local read returns the even byte in bits 7:0 and the odd byte in bits 15:8.
- R8: During a local write, `loc_be[0]` enables the even byte and `loc_be[1]` enables the odd byte. A byte whose enable is low is left unchanged.
- R9: A local access to a word outside 0x100–0x203 reads 0x0000, and a write there changes no stored byte.
- R10: When `host_req` and `loc_req` are both high, the host access is performed and `loc_ready` is low, so the local access is not performed. `loc_ready` equals `loc_req` whenever `host_req` is low. A local write held over a collision lands after the host access to the same word.
- R11: Read data is registered. It changes at the clock edge that accepts the read, and it holds between reads of its own side.
- R12: The mailbox is reached at host offsets 0x200, 0x202, 0x204 and 0x206, which correspond to local bytes 0x200 through 0x203. Both sides may write it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_req | input | 1 | Host access request for this cycle |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | 10 | Host byte offset |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, valid the cycle after the request |
| loc_req | input | 1 | Local access request, held until accepted |
| loc_we | input | 1 | Local write (1) or read (0) |
| loc_addr | input | 10 | Local byte address, word aligned by the block |
| loc_be | input | 2 | Local byte enables, bit 0 even byte, bit 1 odd byte |
| loc_wdata | input | 16 | Local write word |
| loc_rdata | output | 16 | Local read word, valid the cycle after acceptance |
| loc_ready | output | 1 | Local request accepted this cycle |

## Verification
The hardest case to reach from the ports is a same-cycle collision in which both sides write the same storage word. The write order then decides the final contents. To reach it, the bench raises both request lines at one falling edge and holds the local request through the wait cycle. It then releases the host and reads the word back from both sides, checking that the local byte, which was applied second, is the one that stays. A second collision pairs a host read with a local write, so the host data and the deferred local write are both visible.

// File: rtl/attr_pkg.sv
package attr_pkg;

  localparam int HOST_AW = 10;
  localparam int LOC_AW  = 10;
  localparam int LANE_W  = 8;
  localparam int LANES   = 2;
  localparam int WORD_W  = LANE_W * LANES;

  // Dense local map, in byte addresses
  localparam logic [LOC_AW-1:0] LOC_BASE  = 10'h100;
  localparam logic [LOC_AW-1:0] LOC_BAR   = 10'h178;
  localparam logic [LOC_AW-1:0] LOC_CFG   = 10'h180;
  localparam logic [LOC_AW-1:0] LOC_CIS2  = 10'h188;
  localparam logic [LOC_AW-1:0] LOC_MBX   = 10'h200;
  localparam int                MBX_BYTES = 4;
  localparam logic [LOC_AW-1:0] LOC_LIMIT = LOC_MBX + LOC_AW'(MBX_BYTES);

  localparam int DEPTH = (int'(LOC_LIMIT) - int'(LOC_BASE)) / LANES;
  localparam int IDX_W = $clog2(DEPTH);

  typedef enum logic [2:0] {
    RGN_NONE,
    RGN_CIS,
    RGN_BAR,
    RGN_CFG,
    RGN_MBX
  } region_t;

  // Region of a dense local byte address
  function automatic region_t region_of(input logic [LOC_AW-1:0] a);
    if (a < LOC_BASE)       return RGN_NONE;
    else if (a < LOC_BAR)   return RGN_CIS;
    else if (a < LOC_CFG)   return RGN_BAR;
    else if (a < LOC_CIS2)  return RGN_CFG;
    else if (a < LOC_MBX)   return RGN_CIS;
    else if (a < LOC_LIMIT) return RGN_MBX;
    else                    return RGN_NONE;
  endfunction

  // Sparse host offset -> dense local byte address (even host bytes only)
  function automatic logic [LOC_AW-1:0] host_to_loc(input logic [HOST_AW-1:0] h);
    return LOC_BASE + LOC_AW'(h >> 1);
  endfunction

  // Storage word holding a mapped local byte address
  function automatic logic [IDX_W-1:0] word_of(input logic [LOC_AW-1:0] a);
    logic [LOC_AW-1:0] d;
    d = (a - LOC_BASE) >> 1;
    return d[IDX_W-1:0];
  endfunction

  function automatic logic host_may_write(input region_t r);
    return (r == RGN_BAR) || (r == RGN_CFG) || (r == RGN_MBX);
  endfunction

endpackage

// File: rtl/attr_host_decode.sv
module attr_host_decode
  import attr_pkg::*;
(
  input  logic [HOST_AW-1:0] addr,
  output logic [LOC_AW-1:0]  loc_equiv,
  output region_t            region,
  output logic               hit,
  output logic [IDX_W-1:0]   idx,
  output logic               lane
);
  always_comb begin
    loc_equiv = host_to_loc(addr);
    region    = region_of(loc_equiv);
    hit       = !addr[0] && (region != RGN_NONE);
    idx       = word_of(loc_equiv);
    lane      = loc_equiv[0];
  end
endmodule

// File: rtl/attr_loc_decode.sv
module attr_loc_decode
  import attr_pkg::*;
(
  input  logic [LOC_AW-1:0] addr,
  output region_t           region,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  logic [LOC_AW-1:0] aligned;

  always_comb begin
    aligned = {addr[LOC_AW-1:1], 1'b0};
    region  = region_of(aligned);
    hit     = (region != RGN_NONE);
    idx     = word_of(aligned);
  end
endmodule

// File: rtl/attr_arbiter.sv
module attr_arbiter (
  input  logic host_req,
  input  logic loc_req,
  output logic host_go,
  output logic loc_go,
  output logic loc_ready
);
  // Host has fixed priority; the local side waits while the host is active
  always_comb begin
    host_go   = host_req;
    loc_ready = loc_req && !host_req;
    loc_go    = loc_ready;
  end
endmodule

// File: rtl/attr_store.sv
module attr_store #(
  parameter int DEPTH  = 130,
  parameter int IDX_W  = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [IDX_W-1:0]        idx,
  input  logic [LANES-1:0]        be,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) bank[i] <= '0;
      end else if (we && be[g]) begin
        bank[idx] <= wdata[g*LANE_W +: LANE_W];
      end
    end

    assign rdata[g*LANE_W +: LANE_W] = bank[idx];
  end
endmodule

// File: rtl/attr_dual_mem.sv
module attr_dual_mem
  import attr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_req,
  input  logic                host_we,
  input  logic [HOST_AW-1:0]  host_addr,
  input  logic [LANE_W-1:0]   host_wdata,
  output logic [LANE_W-1:0]   host_rdata,
  input  logic                loc_req,
  input  logic                loc_we,
  input  logic [LOC_AW-1:0]   loc_addr,
  input  logic [LANES-1:0]    loc_be,
  input  logic [WORD_W-1:0]   loc_wdata,
  output logic [WORD_W-1:0]   loc_rdata,
  output logic                loc_ready
);
  // Named internal events (observed by the bound checker)
  logic               host_go, loc_go;
  logic               host_hit, loc_hit, host_lane;
  logic               host_wr_fire, loc_wr_fire, store_we;
  region_t            host_region, loc_region;
  logic [LOC_AW-1:0]  host_loc;
  logic [IDX_W-1:0]   host_idx, loc_idx, acc_idx;
  logic [LANES-1:0]   acc_be;
  logic [WORD_W-1:0]  acc_wdata, store_rdata;

  attr_arbiter u_arb (
    .host_req (host_req),
    .loc_req  (loc_req),
    .host_go  (host_go),
    .loc_go   (loc_go),
    .loc_ready(loc_ready)
  );

  attr_host_decode u_hdec (
    .addr     (host_addr),
    .loc_equiv(host_loc),
    .region   (host_region),
    .hit      (host_hit),
    .idx      (host_idx),
    .lane     (host_lane)
  );

  attr_loc_decode u_ldec (
    .addr  (loc_addr),
    .region(loc_region),
    .hit   (loc_hit),
    .idx   (loc_idx)
  );

  always_comb begin
    host_wr_fire = host_go && host_we && host_hit && host_may_write(host_region);
    loc_wr_fire  = loc_go && loc_we && loc_hit && (|loc_be);
    store_we     = host_wr_fire || loc_wr_fire;
    if (host_go) begin
      acc_idx   = host_idx;
      acc_be    = host_lane ? 2'b10 : 2'b01;
      acc_wdata = {LANES{host_wdata}};
    end else begin
      acc_idx   = loc_idx;
      acc_be    = loc_be;
      acc_wdata = loc_wdata;
    end
  end

  attr_store #(
    .DEPTH (DEPTH),
    .IDX_W (IDX_W),
    .LANES (LANES),
    .LANE_W(LANE_W)
  ) u_store (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (store_we),
    .idx  (acc_idx),
    .be   (acc_be),
    .wdata(acc_wdata),
    .rdata(store_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rdata <= '0;
      loc_rdata  <= '0;
    end else begin
      if (host_go && !host_we)
        host_rdata <= !host_hit ? '0 :
                      (host_lane ? store_rdata[LANE_W +: LANE_W] : store_rdata[0 +: LANE_W]);
      if (loc_go && !loc_we)
        loc_rdata <= loc_hit ? store_rdata : '0;
    end
  end
endmodule

// File: rtl/attr_dual_mem_checker.sv
module attr_dual_mem_checker
  import attr_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                host_req,
  input logic                host_we,
  input logic [HOST_AW-1:0]  host_addr,
  input logic [LANE_W-1:0]   host_rdata,
  input logic                loc_req,
  input logic                loc_we,
  input logic                loc_ready,
  input logic [WORD_W-1:0]   loc_rdata,
  input logic                host_go,
  input logic                loc_go,
  input logic                host_hit,
  input logic                loc_hit,
  input logic                host_wr_fire,
  input logic                loc_wr_fire,
  input logic                store_we,
  input region_t             host_region
);
  assert_host_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && loc_req) |-> (host_go && !loc_ready));

  assert_local_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_req && !host_req) |-> loc_ready);

  assert_one_writer_R10: assert property (@(posedge clk) disable iff (!rst_n)
    store_we |-> (host_wr_fire != loc_wr_fire));

  assert_odd_host_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && host_we && host_addr[0]) |-> !host_wr_fire);

  assert_cis_host_ro_R6: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr_fire |-> (host_region != RGN_CIS));

  assert_host_miss_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_we && !host_hit) |=> (host_rdata == '0));

  assert_loc_miss_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_go && !loc_we && !loc_hit) |=> (loc_rdata == '0));

  assert_host_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_req && !host_we) |=> $stable(host_rdata));

  assert_loc_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(loc_go && !loc_we) |=> $stable(loc_rdata));
endmodule

bind attr_dual_mem attr_dual_mem_checker u_chk (.*);

// File: tb/tb_attr_dual_mem.sv
module tb_attr_dual_mem;
  localparam logic [1:0] HW = 2'd0, HR = 2'd1, LW = 2'd2, LR = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0, host_we = 1'b0;
  logic [9:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        loc_req = 1'b0, loc_we = 1'b0;
  logic [9:0]  loc_addr = '0;
  logic [1:0]  loc_be = '0;
  logic [15:0] loc_wdata = '0;
  logic [15:0] loc_rdata;
  logic        loc_ready;

  int  n_run = 0, n_fail = 0;
  bit  finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  attr_dual_mem dut (.*);

  // {kind, req, addr, be, data, expect}
  function automatic logic [49:0] vec(input logic [1:0] k, input logic [3:0] r,
      input logic [9:0] a, input logic [1:0] b, input logic [15:0] d, input logic [15:0] e);
    return {k, r, a, b, d, e};
  endfunction

  localparam int NV = 38;
  localparam logic [49:0] TBL [NV] = '{
    vec(LW, 4'd7,  10'h100, 2'b11, 16'hA55A, 16'h0000),  // R7 word write
    vec(HR, 4'd7,  10'h000, 2'b00, 16'h0000, 16'h005A),  // R7 even byte
    vec(HR, 4'd7,  10'h002, 2'b00, 16'h0000, 16'h00A5),  // R7 odd byte
    vec(HR, 4'd3,  10'h001, 2'b00, 16'h0000, 16'h0000),  // R3 odd host read
    vec(HW, 4'd6,  10'h000, 2'b00, 16'h0077, 16'h0000),  // R6 host write to CIS
    vec(HR, 4'd6,  10'h000, 2'b00, 16'h0000, 16'h005A),  // R6 unchanged
    vec(LR, 4'd6,  10'h100, 2'b00, 16'h0000, 16'hA55A),  // R6 local view
    vec(HW, 4'd5,  10'h0F0, 2'b00, 16'h003C, 16'h0000),  // R5 BAR write
    vec(HW, 4'd5,  10'h0F2, 2'b00, 16'h00C3, 16'h0000),  // R5
    vec(LR, 4'd5,  10'h178, 2'b00, 16'h0000, 16'hC33C),  // R5 local sees BAR
    vec(HW, 4'd3,  10'h0F1, 2'b00, 16'h00FF, 16'h0000),  // R3 odd host write
    vec(HR, 4'd3,  10'h0F0, 2'b00, 16'h0000, 16'h003C),  // R3
    vec(LR, 4'd3,  10'h179, 2'b00, 16'h0000, 16'hC33C),  // R3 / R7 bit0 ignored
    vec(HW, 4'd5,  10'h100, 2'b00, 16'h0041, 16'h0000),  // R5 config write
    vec(LR, 4'd5,  10'h180, 2'b00, 16'h0000, 16'h0041),  // R5
    vec(HR, 4'd2,  10'h100, 2'b00, 16'h0000, 16'h0041),  // R2 config map
    vec(LW, 4'd8,  10'h188, 2'b10, 16'h9900, 16'h0000),  // R8 odd-only write
    vec(HR, 4'd8,  10'h112, 2'b00, 16'h0000, 16'h0099),  // R8
    vec(HR, 4'd8,  10'h110, 2'b00, 16'h0000, 16'h0000),  // R8 even untouched
    vec(LW, 4'd8,  10'h1FE, 2'b01, 16'hFF12, 16'h0000),  // R8 even-only write
    vec(LW, 4'd8,  10'h1FE, 2'b10, 16'hEE77, 16'h0000),  // R8 odd-only write
    vec(HR, 4'd2,  10'h1FC, 2'b00, 16'h0000, 16'h0012),  // R2 top of CIS2
    vec(HR, 4'd2,  10'h1FE, 2'b00, 16'h0000, 16'h00EE),  // R2 last byte
    vec(LW, 4'd2,  10'h176, 2'b11, 16'h4400, 16'h0000),  // R2 end of CIS1
    vec(HR, 4'd2,  10'h0EE, 2'b00, 16'h0000, 16'h0044),  // R2
    vec(HW, 4'd12, 10'h204, 2'b00, 16'h006B, 16'h0000),  // R12 host mailbox
    vec(LR, 4'd12, 10'h202, 2'b00, 16'h0000, 16'h006B),  // R12
    vec(LW, 4'd12, 10'h200, 2'b11, 16'h2211, 16'h0000),  // R12 local mailbox
    vec(HR, 4'd12, 10'h200, 2'b00, 16'h0000, 16'h0011),  // R12
    vec(HR, 4'd12, 10'h202, 2'b00, 16'h0000, 16'h0022),  // R12
    vec(HW, 4'd12, 10'h206, 2'b00, 16'h009D, 16'h0000),  // R12 last slot
    vec(LR, 4'd12, 10'h203, 2'b00, 16'h0000, 16'h9D6B),  // R12
    vec(HW, 4'd4,  10'h208, 2'b00, 16'h0055, 16'h0000),  // R4 beyond mailbox
    vec(HR, 4'd4,  10'h208, 2'b00, 16'h0000, 16'h0000),  // R4
    vec(HR, 4'd4,  10'h3FE, 2'b00, 16'h0000, 16'h0000),  // R4 top of space
    vec(LW, 4'd9,  10'h0FE, 2'b11, 16'hBEEF, 16'h0000),  // R9 below map
    vec(LR, 4'd9,  10'h0FE, 2'b00, 16'h0000, 16'h0000),  // R9
    vec(LR, 4'd9,  10'h204, 2'b00, 16'h0000, 16'h0000)   // R9 above map
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic host_op(input logic we, input logic [9:0] a, input logic [7:0] d);
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_req = 1'b0; host_we = 1'b0;
  endtask

  task automatic loc_op(input logic we, input logic [9:0] a, input logic [1:0] b,
                        input logic [15:0] d);
    @(negedge clk);
    loc_req = 1'b1; loc_we = we; loc_addr = a; loc_be = b; loc_wdata = d;
    @(negedge clk);
    loc_req = 1'b0; loc_we = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check("R1 host_rdata", {8'h00, host_rdata}, 16'h0000);
    check("R1 loc_rdata", loc_rdata, 16'h0000);
    loc_op(1'b0, 10'h1A0, 2'b11, 16'h0000);
    check("R1 storage cleared", loc_rdata, 16'h0000);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      logic [49:0] v;
      string tag;
      v = TBL[i];
      tag = $sformatf("R%0d entry %0d", v[47:44], i);
      case (v[49:48])
        HW: host_op(1'b1, v[43:34], v[23:16]);
        HR: begin
          host_op(1'b0, v[43:34], 8'h00);
          check(tag, {8'h00, host_rdata}, v[15:0]);
        end
        LW: loc_op(1'b1, v[43:34], v[33:32], v[31:16]);
        default: begin
          loc_op(1'b0, v[43:34], 2'b00, 16'h0000);
          check(tag, loc_rdata, v[15:0]);
        end
      endcase
    end

    // R11: read data registered, not combinational
    @(negedge clk);
    loc_req = 1'b1; loc_we = 1'b0; loc_addr = 10'h100;
    #1;
    check("R11 before edge", loc_rdata, 16'h0000);
    @(negedge clk);
    loc_req = 1'b0;
    check("R11 after edge", loc_rdata, 16'hA55A);
    @(negedge clk);
    check("R11 hold", loc_rdata, 16'hA55A);

    // R10: host read collides with a local write
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b0; host_addr = 10'h0F0;
    loc_req = 1'b1; loc_we = 1'b1; loc_addr = 10'h17A; loc_be = 2'b11; loc_wdata = 16'h1234;
    #1;
    check("R10 wait on collision", {15'd0, loc_ready}, 16'h0000);
    @(negedge clk);
    host_req = 1'b0;
    check("R10 host served first", {8'h00, host_rdata}, 16'h003C);
    #1;
    check("R10 local ready once alone", {15'd0, loc_ready}, 16'h0001);
    @(negedge clk);
    loc_req = 1'b0; loc_we = 1'b0;
    loc_op(1'b0, 10'h17A, 2'b00, 16'h0000);
    check("R10 deferred write landed", loc_rdata, 16'h1234);

    // R10: both sides write the same byte; local lands last
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b1; host_addr = 10'h0F4; host_wdata = 8'h81;
    loc_req = 1'b1; loc_we = 1'b1; loc_addr = 10'h17A; loc_be = 2'b01; loc_wdata = 16'h0056;
    @(negedge clk);
    host_req = 1'b0; host_we = 1'b0;
    @(negedge clk);
    loc_req = 1'b0; loc_we = 1'b0;
    loc_op(1'b0, 10'h17A, 2'b00, 16'h0000);
    check("R10 write order local view", loc_rdata, 16'h1256);
    host_op(1'b0, 10'h0F4, 8'h00);
    check("R10 write order host view", {8'h00, host_rdata}, 16'h0056);

    finish_run();
  end
endmodule